// File: doc/BRIEF.md
# Word-Serial Stimulus Sequencer

This block drives a single-bit serial device from a small table of stimulus words. On a start request it walks the table one word at a time. Before each word it gives the device a reset pulse one cycle long. In the cycle after that pulse it presents the device's post-reset state. It then streams the word into the device one bit per clock, most significant bit first.

After every applied bit, the sequencer raises a capture strobe. The strobe carries the word index, the bit index, and the state and output the device shows as a result of that bit. A surrounding test environment, or an on-chip self-test, can record these values and compare them against a model. Loading the table and judging the results both happen outside the block.

The table sits behind a read port with one cycle of latency. The sequencer issues the address of the next word during the reset cycle, so no cycle is lost per word. Each word therefore takes exactly ten cycles: one reset, one initial sample, and eight data bits.

Top module: `stim_seq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle on that edge: `dev_rst`, `dev_din`, `init_valid`, `cap_valid` and `done` are 0, and `tbl_addr` is 0. This applies even in the middle of a run.
- R2: When the block is idle and `start` is sampled high, the first `dev_rst` pulse appears in the next cycle, with `tbl_addr` = 0.
- R3: Each `dev_rst` pulse lasts exactly one cycle. Every word is preceded by its own pulse, for 16 pulses per run.
- R4: During the `dev_rst` cycle of word w, `tbl_addr` equals w. The table returns that word in the following cycle (one-cycle read latency).
- R5: In the cycle right after each `dev_rst` pulse, `init_valid` is 1, `dev_din` is 0, and `init_state` equals `dev_state`, the device's state after reset.
- R6: In the 8 cycles after `init_valid`, `dev_din` carries the word's bits from bit 7 down to bit 0, one bit per cycle. Word 8'b10110010 is applied as 1,0,1,1,0,0,1,0.
- R7: In the cycle after each applied bit, `cap_valid` is 1. `cap_word` gives the word index and `cap_bit` the bit index, where 0 is the first (MSB) bit. `cap_state` and `cap_out` show the device's state and output in that cycle. When `cap_valid` is 0, `cap_state` and `cap_out` are 0.
- R8: After the capture of word 15, bit 7, `done` is 1 and stays 1 while `start` stays high. `done` drops one cycle after `start` is sampled low. A full run spans 161 cycles from the start edge to the first cycle with `done` high.
- R9: A change on `start` while a run is in progress has no effect on the sequence or its timing.
- R10: Outside the data-bit cycles, `dev_din` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Run request; sampled while idle |
| tbl_addr | output | 4 | Stimulus table read address |
| tbl_data | input | 8 | Stimulus word, valid one cycle after address |
| dev_rst | output | 1 | One-cycle reset pulse to the device |
| dev_din | output | 1 | Serial data bit to the device |
| dev_state | input | 3 | Device state |
| dev_out | input | 1 | Device output |
| init_valid | output | 1 | Post-reset state sample strobe |
| init_state | output | 3 | Device state after reset |
| cap_valid | output | 1 | Per-bit capture strobe |
| cap_word | output | 4 | Word index of the capture |
| cap_bit | output | 3 | Bit index of the capture, 0 = MSB |
| cap_state | output | 3 | Device state after the bit |
| cap_out | output | 1 | Device output after the bit |
| done | output | 1 | All words played |

## Verification
The bench plays a 16-word table through a model device whose state is a history of the last three bits it received and whose output is the last bit. Any capture therefore shows exactly which bits arrived, and in what order.

The table mixes three kinds of words: asymmetric words such as 10110010, which separate MSB-first from LSB-first order; all-ones and all-zeros words, which expose a skipped or repeated bit through the history; and words whose last bits differ from the next word's first bits, which reveal a missing device reset through a nonzero initial state.

Directed runs add three more cases. One toggles `start` in the middle of a run and counts cycles to `done`. One holds `start` high past the end of a run. One applies `rst_n` in the middle of a run.

// File: rtl/stim_seq_pkg.sv
// Shared types for the stimulus sequencer.
// Assumes: a single clock domain; every user needs only the controller state type.
package stim_seq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_RESET = 3'd1,
        SQ_INIT  = 3'd2,
        SQ_SHIFT = 3'd3,
        SQ_DONE  = 3'd4
    } sq_state_t;
endpackage

// File: rtl/stim_seq_ctrl.sv
// Controller: walks the word table and steps through reset, initial sample and bit shifting.
// Assumes: tbl_data arrives one cycle after the address; reset is synchronous, active low.
module stim_seq_ctrl
    import stim_seq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output sq_state_t        st_q,
    output logic [IDX_W-1:0] word_q,
    output logic [BIT_W-1:0] bit_q,
    output logic             load_en,
    output logic             shift_en
);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(DEPTH - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

    sq_state_t st_d;

    // Next-state decision for the sequencing state machine.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:  if (start) st_d = SQ_RESET;
            SQ_RESET: st_d = SQ_INIT;
            SQ_INIT:  st_d = SQ_SHIFT;
            SQ_SHIFT: if (bit_q == LAST_BIT)
                          st_d = (word_q == LAST_WORD) ? SQ_DONE : SQ_RESET;
            SQ_DONE:  if (!start) st_d = SQ_IDLE;
            default:  st_d = SQ_IDLE;
        endcase
    end

    // State, word index and bit index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            word_q <= '0;
            bit_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE)
                word_q <= '0;
            else if (st_q == SQ_SHIFT && bit_q == LAST_BIT && word_q != LAST_WORD)
                word_q <= word_q + 1'b1;
            if (st_q == SQ_SHIFT)
                bit_q <= bit_q + 1'b1;
            else
                bit_q <= '0;
        end
    end

    // Datapath controls derived from the state.
    assign load_en  = (st_q == SQ_INIT);
    assign shift_en = (st_q == SQ_SHIFT);
endmodule

// File: rtl/stim_seq_shifter.sv
// Parallel-load shift register that presents the word MSB first.
// Assumes: load and shift are never asserted together.
module stim_seq_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic              msb
);
    logic [WORD_W-1:0] sr_q;

    // Load a word or move it one place towards the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (load_en)  sr_q <= din;
        else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
    end

    assign msb = sr_q[WORD_W-1];
endmodule

// File: rtl/stim_seq_capture.sv
// Capture stage: flags the cycle after each applied bit and tags it with its word and bit index.
// Assumes: the device's response to a bit is visible in the cycle after the bit is applied.
module stim_seq_capture #(
    parameter int IDX_W = 4,
    parameter int BIT_W = 3,
    parameter int ST_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_applied,
    input  logic [IDX_W-1:0] word_in,
    input  logic [BIT_W-1:0] bit_in,
    input  logic [ST_W-1:0]  dev_state,
    input  logic             dev_out,
    output logic             cap_valid,
    output logic [IDX_W-1:0] cap_word,
    output logic [BIT_W-1:0] cap_bit,
    output logic [ST_W-1:0]  cap_state,
    output logic             cap_out
);
    // Delay the bit strobe and its tags by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_word  <= '0;
            cap_bit   <= '0;
        end else begin
            cap_valid <= bit_applied;
            cap_word  <= word_in;
            cap_bit   <= bit_in;
        end
    end

    // Pass the device response through only while the strobe is high.
    assign cap_state = cap_valid ? dev_state : '0;
    assign cap_out   = cap_valid & dev_out;
endmodule

// File: rtl/stim_seq_top.sv
// Word-serial stimulus sequencer: resets the device, samples its initial state,
// then shifts each table word in MSB first and captures the response per bit.
// Assumes: synchronous table read with one cycle of latency; device reset is synchronous.
module stim_seq_top
    import stim_seq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 8,
    parameter int ST_W   = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [IDX_W-1:0]  tbl_addr,
    input  logic [WORD_W-1:0] tbl_data,
    output logic              dev_rst,
    output logic              dev_din,
    input  logic [ST_W-1:0]   dev_state,
    input  logic              dev_out,
    output logic              init_valid,
    output logic [ST_W-1:0]   init_state,
    output logic              cap_valid,
    output logic [IDX_W-1:0]  cap_word,
    output logic [BIT_W-1:0]  cap_bit,
    output logic [ST_W-1:0]   cap_state,
    output logic              cap_out,
    output logic              done
);
    sq_state_t        st_q;
    logic [IDX_W-1:0] word_q;
    logic [BIT_W-1:0] bit_q;
    logic             load_en;
    logic             shift_en;
    logic             sh_msb;

    stim_seq_ctrl #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .st_q     (st_q),
        .word_q   (word_q),
        .bit_q    (bit_q),
        .load_en  (load_en),
        .shift_en (shift_en)
    );

    stim_seq_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .din      (tbl_data),
        .msb      (sh_msb)
    );

    stim_seq_capture #(.IDX_W(IDX_W), .BIT_W(BIT_W), .ST_W(ST_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_applied (shift_en),
        .word_in     (word_q),
        .bit_in      (bit_q),
        .dev_state   (dev_state),
        .dev_out     (dev_out),
        .cap_valid   (cap_valid),
        .cap_word    (cap_word),
        .cap_bit     (cap_bit),
        .cap_state   (cap_state),
        .cap_out     (cap_out)
    );

    // Device-facing controls and status outputs.
    assign tbl_addr   = word_q;
    assign dev_rst    = (st_q == SQ_RESET);
    assign dev_din    = shift_en & sh_msb;
    assign init_valid = load_en;
    assign init_state = load_en ? dev_state : '0;
    assign done       = (st_q == SQ_DONE);
endmodule

// File: rtl/stim_seq_checker.sv
// Protocol checker for the stimulus sequencer, bound to the top module.
// Assumes: it observes only ports plus the controller state.
module stim_seq_checker
    import stim_seq_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      start,
    input sq_state_t st_q,
    input logic      dev_rst,
    input logic      dev_din,
    input logic      init_valid,
    input logic      cap_valid,
    input logic [2:0] cap_bit,
    input logic      done
);
    p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> !dev_rst);

    p_init_follows_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> init_valid && !dev_din);

    p_start_kicks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_IDLE && start) |=> dev_rst);

    p_bit_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_bit != 3'd7) |=> cap_valid && cap_bit == $past(cap_bit) + 3'd1);

    p_last_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_bit == 3'd7) |=> !cap_valid);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dev_rst && !dev_din && !init_valid);
endmodule

bind stim_seq_top stim_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .st_q       (st_q),
    .dev_rst    (dev_rst),
    .dev_din    (dev_din),
    .init_valid (init_valid),
    .cap_valid  (cap_valid),
    .cap_bit    (cap_bit),
    .done       (done)
);

// File: tb/sim_stim_seq_top.sv
`timescale 1ns/1ps
module sim_stim_seq_top;
    localparam logic [7:0] TBL [16] = '{
        8'b10110010, 8'b11111111, 8'b00000000, 8'b10000000,
        8'b00000001, 8'b01010101, 8'b10101010, 8'b11100011,
        8'b00011100, 8'b11001100, 8'b00110011, 8'b01101001,
        8'b10010110, 8'b11110000, 8'b00001111, 8'b10110111
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] tbl_addr;
    logic [7:0] tbl_data;
    logic       dev_rst, dev_din, init_valid, cap_valid, cap_out, done;
    logic [2:0] dev_state, init_state, cap_bit, cap_state;
    logic [3:0] cap_word;
    logic       dev_out;
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;

    always #2.5 clk = ~clk;

    stim_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .dev_rst(dev_rst), .dev_din(dev_din),
        .dev_state(dev_state), .dev_out(dev_out),
        .init_valid(init_valid), .init_state(init_state),
        .cap_valid(cap_valid), .cap_word(cap_word), .cap_bit(cap_bit),
        .cap_state(cap_state), .cap_out(cap_out), .done(done)
    );

    // Table with one cycle of read latency.
    always_ff @(posedge clk) tbl_data <= TBL[tbl_addr];

    // Model device: state = last three bits received, output = last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || dev_rst) begin
            dev_state <= 3'b000;
            dev_out   <= 1'b0;
        end else begin
            dev_state <= {dev_state[1:0], dev_din};
            dev_out   <= dev_din;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_idle(input string req);
        chk(!dev_rst && !dev_din && !init_valid && !cap_valid && !done && tbl_addr == 0,
            req, {dev_rst, dev_din, init_valid, cap_valid, done, tbl_addr}, 0);
    endtask

    initial begin
        logic [2:0] eh;
        logic       prev_bit;
        int         n;
        step(); step();
        chk_idle("R1 reset state");
        rst_n = 1'b1;
        step();
        chk_idle("R1 idle after reset");

        // Main walk over the table, start held high throughout (R8 hold).
        start = 1'b1;
        eh = 3'b000;
        prev_bit = 1'b0;
        for (int w = 0; w < 16; w++) begin
            step();  // reset cycle
            chk(dev_rst == 1'b1, "R3 reset pulse", dev_rst, 1);
            chk(tbl_addr == w[3:0], "R4 address in reset cycle", tbl_addr, w);
            if (w == 0) chk(dev_din == 1'b0 && !cap_valid, "R2 first pulse", dev_din, 0);
            else chk(cap_valid && cap_bit == 3'd7 && cap_word == 4'(w - 1) &&
                     cap_state == eh && cap_out == prev_bit,
                     "R7 last-bit capture", {cap_valid, cap_word, cap_bit, cap_state}, {1'b1, 4'(w - 1), 3'd7, eh});
            step();  // initial sample cycle
            chk(init_valid && !dev_rst && !dev_din && init_state == 3'b000,
                "R5 initial sample", {init_valid, dev_rst, init_state}, {1'b1, 1'b0, 3'b000});
            eh = 3'b000;
            for (int k = 0; k < 8; k++) begin
                step();  // bit k applied
                chk(dev_din == TBL[w][7-k], "R6 MSB-first bit", dev_din, TBL[w][7-k]);
                if (k > 0)
                    chk(cap_valid && cap_bit == 3'(k - 1) && cap_word == w[3:0] &&
                        cap_state == eh && cap_out == prev_bit,
                        "R7 capture", {cap_valid, cap_word, cap_bit, cap_state, cap_out},
                        {1'b1, w[3:0], 3'(k - 1), eh, prev_bit});
                else
                    chk(!cap_valid && cap_state == 3'b000, "R7 no strobe at first bit", cap_valid, 0);
                eh = {eh[1:0], TBL[w][7-k]};
                prev_bit = TBL[w][7-k];
            end
        end
        step();  // first DONE cycle
        chk(done && cap_valid && cap_word == 4'd15 && cap_bit == 3'd7 && cap_state == eh,
            "R8 done with final capture", {done, cap_word, cap_bit}, {1'b1, 4'd15, 3'd7});
        for (int i = 0; i < 5; i++) begin
            step();
            chk(done && !dev_rst && !dev_din, "R8 done held under start", done, 1);
            chk(!cap_valid && cap_state == 3'b000 && !cap_out, "R10 quiet after run", cap_valid, 0);
        end
        start = 1'b0;
        step();
        chk(!done && !dev_rst, "R8 done clears after start low", done, 0);
        step();
        chk_idle("R8 back to idle");

        // Start toggled during a run must not change timing (R9).
        start = 1'b1;
        step();
        start = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            if (n == 37 || n == 90) start = 1'b1;
            if (n == 39 || n == 95) start = 1'b0;
            step();
            n++;
        end
        chk(n == 161, "R9 run length unaffected by start", n, 161);
        chk(done == 1'b1, "R9 run completes", done, 1);
        step();
        chk(!done, "R8 done drops with start low", done, 1'b0);

        // Reset in the middle of a run (R1).
        start = 1'b1;
        step();
        start = 1'b0;
        for (int i = 0; i < 14; i++) step();
        rst_n = 1'b0;
        step();
        chk_idle("R1 mid-run reset");
        rst_n = 1'b1;
        step(); step();
        chk_idle("R1 stays idle without start");
        chk(dev_state == 3'b000, "R1 device cleared", dev_state, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule